// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sequences the power modes of a small processor system. Software reaches it over a simple register bus. It writes a mode-control register to put the system into idle or power-down, and it writes a peripheral-enable register to switch individual peripheral clocks off. The block drives a processor clock-enable, an oscillator-enable, a global clock-enable and one clock-enable for each peripheral. It returns the system to run mode when a qualifying interrupt arrives or when reset is applied.

Idle stops only the processor clock, and any interrupt ends it, whether the interrupt comes from a peripheral or from an external pin. Power-down stops the oscillator and every clock. Only an external interrupt, which can be detected without a clock, ends power-down. When that wake occurs, hardware clears the mode bits. If one write sets both mode bits, power-down wins. The interrupt inputs are request lines that have already been masked, so an asserted line counts as an enabled interrupt.

Top module: `pwr_mode_ctl`

## Requirements
- R1: After reset the idle and power-down bits are 0 and the peripheral-enable register is all ones. The processor, oscillator, global and peripheral clock-enables are all 1.
- R2: A write to offset 0x0 loads the idle bit from data bit 0 and the power-down bit from data bit 1. Data bits 7:2 are ignored. A read of offset 0x0 returns the idle bit in bit 0 and the power-down bit in bit 1.
- R3: When only the idle bit is set, the processor clock-enable is still 1 in the cycle after the write edge and falls at the following edge. The oscillator, global and peripheral clock-enables stay on.
- R4: When the power-down bit is set, the processor, oscillator, global and every peripheral clock-enable are all 0 from the second edge after the write.
- R5: A write of 0b11 to the mode register gives power-down behaviour (R4, R7), not idle.
- R6: In idle, an asserted peripheral or external interrupt line clears the idle bit at the next edge. The processor clock-enable returns to 1 one edge later.
- R7: In power-down, an asserted external interrupt line clears both the power-down bit and the idle bit, and the clocks return one edge later. Peripheral interrupt lines have no effect in power-down.
- R8: Offset 0x4 is a 32-bit read/write peripheral-enable register. Bit i ANDed with the global clock-enable gives peripheral clock-enable i.
- R9: If a mode write and an interrupt fall in the same cycle, the write takes effect. The wake check then applies at the next edge, using the new bits.
- R10: Reset asserted during idle or power-down returns the block to the R1 state.
- R11: Writes to any offset other than 0x0 and 0x4 change nothing, and reads of such offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_periph | input | NPI | Enabled peripheral interrupt requests |
| irq_ext | input | NEI | Enabled external interrupt requests |
| cpu_clk_en | output | 1 | Processor clock-enable |
| osc_en | output | 1 | Oscillator enable |
| gclk_en | output | 1 | Global clock-enable |
| periph_clk_en | output | NPERIPH | Per-peripheral clock-enables |

## Verification
A mode write and a wake interrupt can land in the same cycle. The bench provokes this by holding an interrupt line high while it writes the idle bit, or both mode bits. It then reads the mode register right after the write edge and expects the written bits. One edge later it expects them cleared, and one edge after that it expects the processor clock-enable back to 1. The table walk also pairs every mode with both interrupt kinds, which confirms that a peripheral interrupt is rejected in power-down.

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl #(
  parameter int ADDR_W  = 4,
  parameter int NPERIPH = 32,
  parameter int NPI     = 4,
  parameter int NEI     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPI-1:0]    irq_periph,
  input  logic [NEI-1:0]    irq_ext,
  output logic              cpu_clk_en,
  output logic              osc_en,
  output logic              gclk_en,
  output logic [NPERIPH-1:0] periph_clk_en
);
  localparam logic [ADDR_W-1:0] OFS_MODE = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_PEN  = ADDR_W'(4);

  logic idl, pd, cpu_q, gclk_q;
  logic [NPERIPH-1:0] pen;

  wire mode_wr = bus_wr && bus_addr == OFS_MODE;
  wire pen_wr  = bus_wr && bus_addr == OFS_PEN;
  wire ext_any = |irq_ext;
  wire irq_any = ext_any || (|irq_periph);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idl <= 1'b0;
      pd  <= 1'b0;
    end else if (mode_wr) begin
      idl <= bus_wdata[0];
      pd  <= bus_wdata[1];
    end else if (pd) begin
      if (ext_any) begin
        pd  <= 1'b0;
        idl <= 1'b0;
      end
    end else if (idl && irq_any) begin
      idl <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pen <= '1;
    else if (pen_wr) pen <= bus_wdata[NPERIPH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_q  <= 1'b1;
      gclk_q <= 1'b1;
    end else begin
      cpu_q  <= !(idl || pd);
      gclk_q <= !pd;
    end
  end

  assign cpu_clk_en    = cpu_q;
  assign gclk_en       = gclk_q;
  assign osc_en        = gclk_q;
  assign periph_clk_en = pen & {NPERIPH{gclk_q}};

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFS_MODE)     bus_rdata[1:0] = {pd, idl};
    else if (bus_addr == OFS_PEN) bus_rdata[NPERIPH-1:0] = pen;
  end

  p_cpu_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && !idl && !pd) |=> cpu_clk_en);

  p_idle_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (idl && !pd && irq_any && !mode_wr) |=> !idl);

  p_pd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pd && !ext_any && !mode_wr) |=> pd);

  p_pd_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pd && ext_any && !mode_wr) |=> (!pd && !idl));

  p_pd_stops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pd && !mode_wr && !ext_any) |=> (!gclk_en && !cpu_clk_en && periph_clk_en == '0));
endmodule

// File: tb/sim_pwr_mode_ctl.sv
module sim_pwr_mode_ctl;
  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [3:0] irq_periph = '0;
  logic [1:0] irq_ext = '0;
  logic cpu_clk_en, osc_en, gclk_en;
  logic [31:0] periph_clk_en;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwr_mode_ctl u0 (.clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .irq_periph, .irq_ext, .cpu_clk_en, .osc_en, .gclk_en, .periph_clk_en);

  // {mode[1:0], irq_p, irq_e, exp_cpu, exp_gclk, exp_read_after[1:0]}
  localparam logic [7:0] VEC [8] = '{
    8'b01_10_0_1_00, 8'b01_01_0_1_00, 8'b10_10_0_0_10, 8'b10_01_0_0_00,
    8'b11_10_0_0_11, 8'b11_01_0_0_00, 8'b00_11_1_1_00, 8'b01_00_0_1_01};

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 4'h0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 mode", bus_rdata, 32'h0);
    chk("R1 clks", {29'b0, cpu_clk_en, osc_en, gclk_en}, 32'h7);
    chk("R1 periph", periph_clk_en, 32'hFFFF_FFFF);
    rst_n = 1'b1;
    @(negedge clk);
    bus_addr = 4'h4;
    #1 chk("R1 pen", bus_rdata, 32'hFFFF_FFFF);
    bus_addr = 4'h0;

    // R8 peripheral enable register
    wr(4'h4, 32'hA5C3_0F96);
    bus_addr = 4'h4;
    #1 chk("R8 pen read", bus_rdata, 32'hA5C3_0F96);
    chk("R8 gating run", periph_clk_en, 32'hA5C3_0F96);
    bus_addr = 4'h0;

    // R2/R3/R4/R5/R6/R7 table walk
    foreach (VEC[i]) begin
      logic [7:0] v;
      v = VEC[i];
      wr(4'h0, {30'b0, v[7:6]});
      chk("R2 read after write", bus_rdata, {30'b0, v[7:6]});
      chk("R3 cpu still on", {31'b0, cpu_clk_en}, 32'h1);
      @(negedge clk);
      chk("R3/R4/R5 cpu_en", {31'b0, cpu_clk_en}, {31'b0, v[3]});
      chk("R3/R4/R5 gclk", {30'b0, gclk_en, osc_en}, {30'b0, v[2], v[2]});
      chk("R4/R8 periph", periph_clk_en, v[2] ? 32'hA5C3_0F96 : 32'h0);
      irq_periph[0] = v[5]; irq_ext[0] = v[4];
      @(negedge clk);
      irq_periph = '0; irq_ext = '0;
      @(negedge clk);
      chk("R6/R7 mode after irq", bus_rdata, {30'b0, v[1:0]});
      chk("R6/R7 cpu after irq", {31'b0, cpu_clk_en}, {31'b0, v[1:0] == 2'b00});
      wr(4'h0, 32'h0);
      @(negedge clk);
    end

    // R2 reserved bits ignored
    wr(4'h0, 32'h0000_00FC);
    chk("R2 reserved", bus_rdata, 32'h0);
    @(negedge clk);
    chk("R2 reserved cpu", {31'b0, cpu_clk_en}, 32'h1);

    // R11 unmapped offset
    wr(4'h8, 32'h0000_0003);
    bus_addr = 4'h8;
    #1 chk("R11 read unmapped", bus_rdata, 32'h0);
    bus_addr = 4'h4;
    #1 chk("R11 pen untouched", bus_rdata, 32'hA5C3_0F96);
    bus_addr = 4'h0;
    #1 chk("R11 mode untouched", bus_rdata, 32'h0);

    // R9 write coincides with interrupt
    @(negedge clk);
    irq_periph[1] = 1'b1;
    bus_wr = 1'b1; bus_wdata = 32'h1;
    @(negedge clk);
    bus_wr = 1'b0;
    chk("R9 idle write wins", bus_rdata, 32'h1);
    @(negedge clk);
    irq_periph = '0;
    chk("R9 idle then woken", bus_rdata, 32'h0);
    @(negedge clk);
    chk("R9 cpu back", {31'b0, cpu_clk_en}, 32'h1);
    irq_ext[1] = 1'b1;
    bus_wr = 1'b1; bus_wdata = 32'h3;
    @(negedge clk);
    bus_wr = 1'b0;
    chk("R9 pd write wins", bus_rdata, 32'h3);
    @(negedge clk);
    irq_ext = '0;
    chk("R9 pd then woken", bus_rdata, 32'h0);

    // R10 reset during power-down
    wr(4'h0, 32'h2);
    @(negedge clk);
    chk("R10 in pd", {31'b0, gclk_en}, 32'h0);
    rst_n = 1'b0;
    #1;
    chk("R10 clks", {29'b0, cpu_clk_en, osc_en, gclk_en}, 32'h7);
    chk("R10 mode", bus_rdata, 32'h0);
    chk("R10 periph", periph_clk_en, 32'hFFFF_FFFF);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule